// File: doc/BRIEF.md
# I2C Slave Address Recognition Unit

This unit sits behind the synchronisers of an I2C slave port. It watches the SCL and SDA lines, detects START and STOP conditions and shifts in every byte on SCL rising edges, most significant bit first. The first byte after a START holds a 7-bit address followed by a read/write bit. When the address equals the programmed own address and the acknowledge-enable input is high, the unit pulls SDA low for the acknowledge clock. It then enters the addressed receiver or transmitter mode and raises an interrupt together with a 5-bit status code.

While an interrupt is pending the unit holds SCL low, which stalls the bus master. The last received byte stays on `rx_byte_o` for as long as `irq_o` is high. A one-cycle `int_clr_i` pulse is the only consumer handshake: it takes the byte and the status, drops the interrupt and releases SCL. When acknowledge-enable is low, START and STOP are still detected and bytes are still shifted in, but the own address gets no acknowledge and raises no interrupt. Recognition resumes at the next START after the enable is set again. Data bytes sent in transmitter mode are driven by other logic. This unit only judges the master's acknowledge and the last-byte indication.

The status code is the upper five bits of an 8-bit status byte whose three low bits are always zero. The code 0x1F (byte 0xF8) means there is no relevant state. The bit timing follows the incoming SCL, so any rate up to 400 kHz works when the system clock is much faster.

Top module: `i2c_addr_rec`

## Requirements
- R1: After reset, status_o is 0x1F, irq_o, sda_pull_o, scl_hold_o and addressed_o are 0.
- R2: With ack_en_i high, a first byte after START equal to {own_addr_i, 0} makes sda_pull_o high during the 9th SCL high phase. It then gives irq_o = 1, status_o = 0x0C (byte 0x60), addressed_o = 1 and dir_read_o = 0.
- R3: With ack_en_i high, a first byte equal to {own_addr_i, 1} is acknowledged the same way. It gives status_o = 0x15 (byte 0xA8) and dir_read_o = 1.
- R4: A first byte whose upper seven bits differ from own_addr_i is not acknowledged and raises no interrupt. addressed_o stays 0.
- R5: With ack_en_i low (sampled at the 8th SCL falling edge), the own address is ignored: no acknowledge, no interrupt, addressed_o stays 0.
- R6: In addressed receiver mode with ack_en_i high, each data byte is acknowledged. It gives status_o = 0x10 (byte 0x80), and rx_byte_o holds the byte.
- R7: In addressed receiver mode with ack_en_i low, a data byte is not acknowledged. It gives status_o = 0x11 (byte 0x88) with rx_byte_o holding the byte, and clearing the interrupt leaves the unit not addressed.
- R8: In not-addressed mode, bytes equal to the own address are ignored until a new START. A START followed by the own address with ack_en_i high is recognised again.
- R9: scl_hold_o is high exactly while irq_o is high. An int_clr_i pulse drops irq_o and returns status_o to 0x1F.
- R10: In transmitter mode, after the 9th clock a master ACK (SDA low) gives status_o 0x17 (byte 0xB8), or 0x19 (byte 0xC8) when last_byte_i is high. A master NACK gives 0x18 (byte 0xC0). After clearing 0x18 or 0x19 the unit is not addressed with SDA released.
- R11: A STOP or a START returns status_o to 0x1F with irq_o and sda_pull_o low and addressed_o low.
- R12: irq_o is high exactly when status_o differs from 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL line level |
| sda_i | input | 1 | Synchronised SDA line level |
| own_addr_i | input | 7 | Programmed own slave address |
| ack_en_i | input | 1 | Acknowledge enable |
| last_byte_i | input | 1 | Byte just sent in transmitter mode was the last one |
| int_clr_i | input | 1 | One-cycle interrupt clear strobe |
| sda_pull_o | output | 1 | Drive SDA low when high |
| scl_hold_o | output | 1 | Drive SCL low (clock stretch) when high |
| addressed_o | output | 1 | Unit is in an addressed slave mode |
| dir_read_o | output | 1 | Read/write bit of the last accepted address |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 5 | Status code (status byte bits 7:3) |
| rx_byte_o | output | 8 | Last byte received in receiver mode |

## Verification
Directed transfers check four address cases: a write address that matches, a read address that matches, an address one bit off, and a matching address sent while acknowledge is disabled. Together they separate the compare, the direction bit and the enable gating. Receive runs toggle the enable from byte to byte, and transmit runs combine master ACK or NACK with the last-byte flag, so every status code and every way back to not-addressed mode is hit. An own-address pattern sent as a data byte after losing addressed mode shows that only the first byte after START is compared. Seeded random transfers mix random and own addresses, directions, enable levels and byte counts, and check against a bench model.

// File: rtl/i2c_arec_pkg.sv
package i2c_arec_pkg;

  // Status code: bits 7:3 of the status byte (low three bits always zero)
  typedef enum logic [4:0] {
    ST_NONE     = 5'h1F,  // 0xF8: nothing to report
    ST_SLAW_ACK = 5'h0C,  // 0x60: own address + write acknowledged
    ST_RXD_ACK  = 5'h10,  // 0x80: data received, ACK returned
    ST_RXD_NACK = 5'h11,  // 0x88: data received, NACK returned
    ST_SLAR_ACK = 5'h15,  // 0xA8: own address + read acknowledged
    ST_TXD_ACK  = 5'h17,  // 0xB8: byte sent, master ACK
    ST_TXD_NACK = 5'h18,  // 0xC0: byte sent, master NACK
    ST_TXD_LAST = 5'h19   // 0xC8: last byte sent, master ACK
  } arec_status_e;

  typedef enum logic [2:0] {
    MD_IDLE,   // not addressed, ignore bytes until START
    MD_ADDR,   // first byte after START expected
    MD_RX,     // addressed receiver
    MD_TX,     // addressed transmitter
    MD_DONE    // transfer finished, leave after interrupt clear
  } arec_mode_e;

endpackage

// File: rtl/arec_line_watch.sv
module arec_line_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    scl_rise  = scl & ~scl_q;
    scl_fall  = ~scl & scl_q;
    // SDA edges are only meaningful while SCL stays high
    start_det = scl & scl_q & sda_q & ~sda;
    stop_det  = scl & scl_q & ~sda_q & sda;
  end

endmodule

// File: rtl/arec_shifter.sv
module arec_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  output logic [BYTE_W-1:0] shreg,
  output logic              ack_bit,
  output logic              byte_done,
  output logic              ack_done
);

  localparam int SLOTS = BYTE_W + 1;
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS);

  logic [CNT_W-1:0] rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      shreg    <= '0;
      ack_bit  <= 1'b1;
    end else if (bus_reset) begin
      rise_cnt <= '0;
    end else if (scl_rise) begin
      if (rise_cnt < LAST_DATA) begin
        shreg <= {shreg[BYTE_W-2:0], sda};
      end else if (rise_cnt == LAST_DATA) begin
        ack_bit <= sda;
      end
      if (rise_cnt < LAST_SLOT) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
    end else if (scl_fall && rise_cnt == LAST_SLOT) begin
      rise_cnt <= '0;
    end
  end

  always_comb begin
    byte_done = scl_fall && !bus_reset && (rise_cnt == LAST_DATA);
    ack_done  = scl_fall && !bus_reset && (rise_cnt == LAST_SLOT);
  end

endmodule

// File: rtl/arec_ctrl.sv
module arec_ctrl
  import i2c_arec_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic              ack_done,
  input  logic              ack_bit,
  input  logic [BYTE_W-1:0] shreg,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              last_byte,
  input  logic              int_clr,
  output logic              sda_pull,
  output logic              irq,
  output logic [4:0]        status,
  output logic              addressed,
  output logic              dir_read,
  output logic [BYTE_W-1:0] rx_byte
);

  arec_mode_e   mode;
  arec_mode_e   pend_mode;
  arec_status_e status_q;
  arec_status_e pend_status;
  logic         pend_valid;
  logic         addr_hit;

  assign addr_hit = ack_en && (shreg[BYTE_W-1:1] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= MD_IDLE;
      pend_mode   <= MD_IDLE;
      status_q    <= ST_NONE;
      pend_status <= ST_NONE;
      pend_valid  <= 1'b0;
      sda_pull    <= 1'b0;
      irq         <= 1'b0;
      dir_read    <= 1'b0;
      rx_byte     <= '0;
    end else if (start_det || stop_det) begin
      mode       <= start_det ? MD_ADDR : MD_IDLE;
      status_q   <= ST_NONE;
      pend_valid <= 1'b0;
      sda_pull   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (irq && int_clr) begin
        irq      <= 1'b0;
        status_q <= ST_NONE;
        if (mode == MD_DONE) begin
          mode <= MD_IDLE;
        end
      end

      if (byte_done) begin
        case (mode)
          MD_ADDR: begin
            if (addr_hit) begin
              sda_pull    <= 1'b1;
              pend_valid  <= 1'b1;
              dir_read    <= shreg[0];
              pend_status <= shreg[0] ? ST_SLAR_ACK : ST_SLAW_ACK;
              pend_mode   <= shreg[0] ? MD_TX : MD_RX;
            end else begin
              mode <= MD_IDLE;
            end
          end
          MD_RX: begin
            pend_valid <= 1'b1;
            if (ack_en) begin
              sda_pull    <= 1'b1;
              pend_status <= ST_RXD_ACK;
              pend_mode   <= MD_RX;
            end else begin
              pend_status <= ST_RXD_NACK;
              pend_mode   <= MD_DONE;
            end
          end
          MD_TX: begin
            pend_valid <= 1'b1;
          end
          default: begin
          end
        endcase
      end

      if (ack_done) begin
        sda_pull   <= 1'b0;
        pend_valid <= 1'b0;
        if (pend_valid) begin
          irq <= 1'b1;
          if (mode == MD_TX) begin
            if (ack_bit) begin
              status_q <= ST_TXD_NACK;
              mode     <= MD_DONE;
            end else if (last_byte) begin
              status_q <= ST_TXD_LAST;
              mode     <= MD_DONE;
            end else begin
              status_q <= ST_TXD_ACK;
            end
          end else begin
            status_q <= pend_status;
            mode     <= pend_mode;
          end
          if (mode == MD_RX) begin
            rx_byte <= shreg;
          end
        end
      end
    end
  end

  always_comb begin
    status    = status_q;
    addressed = (mode == MD_RX) || (mode == MD_TX) || (mode == MD_DONE);
  end

endmodule

// File: rtl/i2c_addr_rec.sv
module i2c_addr_rec #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              last_byte_i,
  input  logic              int_clr_i,
  output logic              sda_pull_o,
  output logic              scl_hold_o,
  output logic              addressed_o,
  output logic              dir_read_o,
  output logic              irq_o,
  output logic [4:0]        status_o,
  output logic [ADDR_W:0]   rx_byte_o
);

  localparam int BYTE_W = ADDR_W + 1;

  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [BYTE_W-1:0] shreg;
  logic              ack_bit;
  logic              byte_done;
  logic              ack_done;

  arec_line_watch u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_i),
    .sda       (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  arec_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (start_det | stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda       (sda_i),
    .shreg     (shreg),
    .ack_bit   (ack_bit),
    .byte_done (byte_done),
    .ack_done  (ack_done)
  );

  arec_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .byte_done (byte_done),
    .ack_done  (ack_done),
    .ack_bit   (ack_bit),
    .shreg     (shreg),
    .own_addr  (own_addr_i),
    .ack_en    (ack_en_i),
    .last_byte (last_byte_i),
    .int_clr   (int_clr_i),
    .sda_pull  (sda_pull_o),
    .irq       (irq_o),
    .status    (status_o),
    .addressed (addressed_o),
    .dir_read  (dir_read_o),
    .rx_byte   (rx_byte_o)
  );

  // Interrupts are only raised at an SCL falling edge, so holding SCL
  // for the whole pending time never shortens a high phase.
  assign scl_hold_o = irq_o;

endmodule

// File: rtl/i2c_addr_rec_chk.sv
module i2c_addr_rec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic       ack_done,
  input logic       ack_en_i,
  input logic       int_clr_i,
  input logic       sda_pull_o,
  input logic       irq_o,
  input logic       addressed_o,
  input logic [4:0] status_o
);

  AST_IRQ_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (status_o != 5'h1F)) else $error("irq/status mismatch"); // R12

  AST_BUS_COND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (status_o == 5'h1F && !irq_o && !sda_pull_o && !addressed_o))
    else $error("bus condition did not clear"); // R11

  AST_PULL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(ack_en_i)) else $error("ack without enable"); // R5

  AST_IRQ_AT_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ack_done)) else $error("irq outside ack slot"); // R2

  AST_IRQ_ONLY_ADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> addressed_o) else $error("irq while not addressed"); // R4

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && int_clr_i) |=> !irq_o) else $error("clear ignored"); // R9

  AST_PULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> $past(ack_done || start_det || stop_det))
    else $error("SDA released early"); // R2

endmodule

bind i2c_addr_rec i2c_addr_rec_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .ack_done    (ack_done),
  .ack_en_i    (ack_en_i),
  .int_clr_i   (int_clr_i),
  .sda_pull_o  (sda_pull_o),
  .irq_o       (irq_o),
  .addressed_o (addressed_o),
  .status_o    (status_o)
);

// File: tb/i2c_addr_rec_bench.sv
module i2c_addr_rec_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own;
  logic       ack_en;
  logic       last_byte;
  logic       int_clr;
  logic       sda_pull, scl_hold, addressed, dir_read, irq;
  logic [4:0] status;
  logic [7:0] rx_byte;
  wire        scl_line = m_scl & ~scl_hold;
  wire        sda_line = m_sda & ~sda_pull;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  i2c_addr_rec u_i2c_addr_rec (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .own_addr_i(own), .ack_en_i(ack_en), .last_byte_i(last_byte),
    .int_clr_i(int_clr), .sda_pull_o(sda_pull), .scl_hold_o(scl_hold),
    .addressed_o(addressed), .dir_read_o(dir_read), .irq_o(irq),
    .status_o(status), .rx_byte_o(rx_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected-value functions derived from the requirements
  function automatic logic [4:0] exp_addr_st(input logic rw);
    return rw ? 5'h15 : 5'h0C;
  endfunction
  function automatic logic [4:0] exp_rx_st(input logic en);
    return en ? 5'h10 : 5'h11;
  endfunction
  function automatic logic [4:0] exp_tx_st(input logic nack, input logic last);
    return nack ? 5'h18 : (last ? 5'h19 : 5'h17);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic v, output logic pulled);
    @(negedge clk) m_sda = v;
    wait_clk(2);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(2);
    pulled = sda_pull;
    wait_clk(1);
    m_scl = 1'b0;
    wait_clk(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ninth, output logic acked);
    logic p;
    for (int i = 7; i >= 0; i--) send_bit(b[i], p);
    send_bit(ninth, p);
    acked = p;
    wait_clk(2);
  endtask

  task automatic do_start();
    @(negedge clk) m_sda = 1'b1;
    wait_clk(2);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(2);
    m_sda = 1'b0;
    wait_clk(2);
    m_scl = 1'b0;
    wait_clk(2);
  endtask

  task automatic do_stop();
    @(negedge clk) m_sda = 1'b0;
    wait_clk(2);
    m_scl = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_clk(2);
    m_sda = 1'b1;
    wait_clk(3);
  endtask

  task automatic clear_irq();
    @(negedge clk) int_clr = 1'b1;
    @(negedge clk) int_clr = 1'b0;
    wait_clk(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    void'($urandom(32'd7341));
    rst_n = 1'b0; own = 7'h2A; ack_en = 1'b1; last_byte = 1'b0; int_clr = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 status", status, 5'h1F);
    chk("R1 irq", irq, 0);
    chk("R1 pull", sda_pull, 0);
    chk("R1 hold", scl_hold, 0);
    chk("R1 addressed", addressed, 0);

    // Write address, acked data, nacked data, then own address as data
    do_start();
    send_byte({7'h2A, 1'b0}, 1'b1, a);
    chk("R2 ack", a, 1);
    chk("R2 irq", irq, 1);
    chk("R2 status", status, 5'h0C);
    chk("R2 addressed", addressed, 1);
    chk("R2 dir", dir_read, 0);
    chk("R9 hold", scl_hold, 1);
    chk("R12 status", status != 5'h1F, irq);
    clear_irq();
    chk("R9 irq", irq, 0);
    chk("R9 status", status, 5'h1F);
    chk("R9 hold", scl_hold, 0);
    send_byte(8'h5C, 1'b1, a);
    chk("R6 ack", a, 1);
    chk("R6 status", status, 5'h10);
    chk("R6 data", rx_byte, 8'h5C);
    clear_irq();
    ack_en = 1'b0;
    send_byte(8'h33, 1'b1, a);
    chk("R7 ack", a, 0);
    chk("R7 status", status, 5'h11);
    chk("R7 data", rx_byte, 8'h33);
    clear_irq();
    chk("R7 addressed", addressed, 0);
    ack_en = 1'b1;
    send_byte({7'h2A, 1'b0}, 1'b1, a);
    chk("R8 ignored ack", a, 0);
    chk("R8 ignored irq", irq, 0);
    do_stop();
    chk("R11 status", status, 5'h1F);
    chk("R11 addressed", addressed, 0);

    // Disabled acknowledge, then recognition after re-enable
    ack_en = 1'b0;
    do_start();
    send_byte({7'h2A, 1'b0}, 1'b1, a);
    chk("R5 ack", a, 0);
    chk("R5 irq", irq, 0);
    chk("R5 addressed", addressed, 0);
    ack_en = 1'b1;
    do_start();
    send_byte({7'h2A, 1'b0}, 1'b1, a);
    chk("R8 resume ack", a, 1);
    chk("R8 resume irq", irq, 1);
    clear_irq();
    do_stop();
    chk("R11 stop addressed", addressed, 0);

    // Address one bit off
    do_start();
    send_byte({7'h2B, 1'b0}, 1'b1, a);
    chk("R4 ack", a, 0);
    chk("R4 irq", irq, 0);
    chk("R4 addressed", addressed, 0);
    do_stop();

    // Transmitter: ACK, last with ACK
    do_start();
    send_byte({7'h2A, 1'b1}, 1'b1, a);
    chk("R3 ack", a, 1);
    chk("R3 status", status, 5'h15);
    chk("R3 dir", dir_read, 1);
    clear_irq();
    last_byte = 1'b0;
    send_byte(8'hFF, 1'b0, a);
    chk("R10 status ack", status, 5'h17);
    clear_irq();
    last_byte = 1'b1;
    send_byte(8'hFF, 1'b0, a);
    chk("R10 status last", status, 5'h19);
    clear_irq();
    chk("R10 addressed", addressed, 0);
    chk("R10 pull", sda_pull, 0);
    do_stop();
    // Transmitter: NACK
    last_byte = 1'b0;
    do_start();
    send_byte({7'h2A, 1'b1}, 1'b1, a);
    clear_irq();
    send_byte(8'hFF, 1'b1, a);
    chk("R10 status nack", status, 5'h18);
    clear_irq();
    chk("R10 nack addressed", addressed, 0);
    do_stop();

    // Random transfers
    for (int it = 0; it < 30; it++) begin
      logic [6:0] adr;
      logic rw, hit, alive;
      int nb;
      own = 7'($urandom);
      adr = ($urandom_range(0, 1) == 1) ? own : 7'($urandom);
      rw  = 1'($urandom);
      ack_en = ($urandom_range(0, 3) != 0);
      hit = ack_en && (adr == own);
      do_start();
      send_byte({adr, rw}, 1'b1, a);
      chk("R2 rnd ack", a, hit);
      chk("R4 rnd irq", irq, hit);
      chk("R3 rnd status", status, hit ? exp_addr_st(rw) : 5'h1F);
      if (irq) clear_irq();
      alive = hit;
      nb = $urandom_range(0, 3);
      for (int k = 0; k < nb; k++) begin
        if (!rw) begin
          logic [7:0] d;
          logic en;
          d = 8'($urandom);
          en = 1'($urandom);
          ack_en = en;
          send_byte(d, 1'b1, a);
          chk("R6 rnd ack", a, alive && en);
          chk("R7 rnd status", status, alive ? exp_rx_st(en) : 5'h1F);
          if (alive) chk("R6 rnd data", rx_byte, d);
          alive = alive && en;
        end else begin
          logic nk, ls;
          nk = 1'($urandom);
          ls = 1'($urandom);
          last_byte = ls;
          send_byte(8'hFF, nk, a);
          chk("R10 rnd status", status, alive ? exp_tx_st(nk, ls) : 5'h1F);
          alive = alive && !nk && !ls;
        end
        if (irq) clear_irq();
        chk("R8 rnd addressed", addressed, alive);
      end
      do_stop();
      chk("R11 rnd addressed", addressed, 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule